// File: doc/BRIEF.md
# Multi-Stream Wall Clock Gate

This block keeps a shared 64-bit wall-clock register that several audio streams read as their common time base. A controller offers a proposed new time together with an optional force bit. Each stream reports whether it is active, whether it has already moved past the proposal, and how much absolute time it has used up. The register moves only when every active stream agrees, so the shared clock never runs ahead of a stream that is lagging.

On an agreed update the register takes the largest of the proposal and the times of the active streams, so the clock catches up with the fastest stream. A forced update writes the proposal unchanged and does not look at the streams. An agreed update that would move the clock backwards is refused and reported as an error. A run of agreed updates that leave the value where it was points to a stalled stream, so the block counts them and raises a warning once the run becomes too long. One cycle after each request the block reports whether the register now holds the value the request aimed for (applied) or not (delayed).

The request side uses a valid/ready handshake. Ready is held high at all times: a request is taken in every cycle that valid is high, and there is no back-pressure. The result is a single-cycle pulse with no ready, so whoever makes the requests must capture it in that cycle.

Top module: `wallclock_gate`

## Requirements
- R1: A request without force changes the register only when every active stream has its passed flag high. Otherwise the register keeps its value and the result reports delayed (applied low).
- R2: A stream whose active bit is low counts as passed, and its time is left out of the maximum.
- R3: An agreed request without force writes the largest of the proposal and the times of all active streams. Stream i's time sits in bits [i*64 +: 64] of the packed time bus.
- R4: A request with force writes the proposal whatever the stream flags say, even when the proposal is below the current value.
- R5: When an agreed request without force computes a value below the current register, the register keeps its value, the error flag is high in the result cycle, and applied is low.
- R6: Each agreed request without force that writes the value already held raises a run counter by one. The stale warning is high in the result cycle of the fourth such write in a row and of every later one. Any agreed request without force that changes the value clears the counter. Forced, delayed and refused requests leave the counter as it is.
- R7: The result valid flag is high exactly one cycle after each accepted request. In that same cycle the register output already shows its new value, and applied is high exactly when the register equals the value the request aimed for.
- R8: After reset the register reads 0, the result valid, applied, error and stale flags are all low, and the run counter is 0.
- R9: The request ready output is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Always high; a request is accepted in any cycle |
| req_force | input | 1 | Write the proposal without checking the streams |
| req_value | input | 64 | Proposed wall-clock value |
| strm_active | input | NUM_STREAMS | Per-stream active mask |
| strm_passed | input | NUM_STREAMS | Per-stream flag: the stream has passed the proposal |
| strm_time | input | NUM_STREAMS*64 | Packed absolute elapsed times, stream i at [i*64 +: 64] |
| wclk_value | output | 64 | Current wall-clock register |
| done_valid | output | 1 | Result pulse, one cycle after a request |
| done_applied | output | 1 | Register equals the value the request aimed for |
| err_backward | output | 1 | An agreed update tried to move the clock backwards |
| stale_warn | output | 1 | Run of unchanged writes went past the limit |

## Verification
The bench goes after the cases a careless design gets wrong. An inactive stream carrying a very large time must not pull the maximum up, and an inactive stream that has not passed must not block the update; a design that skipped the mask would stall or jump ahead. A forced write below the current value must go through, while the same value without force must be refused with the error flag; a design that mixed up the two would either let the clock run backwards or block recovery. Long runs of unchanged writes check that the warning comes on the fourth write and not the third, and that forced or delayed requests inside the run neither clear the counter nor add to it. Random requests with times close to the current value cover the remaining mix of delayed, applied and refused outcomes.

// File: rtl/wcg_pkg.sv
package wcg_pkg;
  typedef enum logic [1:0] {
    OUT_DELAYED  = 2'd0,
    OUT_APPLIED  = 2'd1,
    OUT_BACKWARD = 2'd2
  } outcome_e;
endpackage

// File: rtl/wcg_gate_eval.sv
module wcg_gate_eval #(
  parameter int NUM_STREAMS = 3
) (
  input  logic [NUM_STREAMS-1:0] active,
  input  logic [NUM_STREAMS-1:0] passed,
  output logic                   all_passed
);
  logic [NUM_STREAMS-1:0] ok_vec;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_ok
    assign ok_vec[i] = passed[i] | ~active[i];
  end

  assign all_passed = &ok_vec;

  always_comb begin
    if (active == '0) AST_IDLE_MASK_PASSES: assert (all_passed); // R2
  end
endmodule

// File: rtl/wcg_max_sel.sv
module wcg_max_sel #(
  parameter int NUM_STREAMS = 3,
  parameter int WCLK_W      = 64
) (
  input  logic [WCLK_W-1:0]             seed,
  input  logic [NUM_STREAMS-1:0]        active,
  input  logic [NUM_STREAMS*WCLK_W-1:0] times,
  output logic [WCLK_W-1:0]             max_out
);
  logic [WCLK_W-1:0] stage [NUM_STREAMS+1];

  assign stage[0] = seed;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_chain
    logic [WCLK_W-1:0] t_i;
    assign t_i = times[i*WCLK_W +: WCLK_W];
    assign stage[i+1] = (active[i] && (t_i > stage[i])) ? t_i : stage[i];
  end

  assign max_out = stage[NUM_STREAMS];

  always_comb begin
    AST_MAX_NOT_BELOW_SEED: assert (max_out >= seed); // R3
  end
endmodule

// File: rtl/wcg_stale_track.sv
module wcg_stale_track #(
  parameter int STALE_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic same,
  output logic warn_next
);
  localparam int CNT_W = $clog2(STALE_LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STALE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(STALE_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc   = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign warn_next = upd && same && (cnt_inc > CNT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd) begin
      cnt_q <= same ? cnt_inc : '0;
    end
  end

  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !same) |=> (cnt_q == '0)); // R6
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/wallclock_gate.sv
module wallclock_gate #(
  parameter int NUM_STREAMS = 3,
  parameter int WCLK_W      = 64,
  parameter int STALE_LIMIT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_force,
  input  logic [WCLK_W-1:0]             req_value,
  input  logic [NUM_STREAMS-1:0]        strm_active,
  input  logic [NUM_STREAMS-1:0]        strm_passed,
  input  logic [NUM_STREAMS*WCLK_W-1:0] strm_time,
  output logic [WCLK_W-1:0]             wclk_value,
  output logic                          done_valid,
  output logic                          done_applied,
  output logic                          err_backward,
  output logic                          stale_warn
);
  import wcg_pkg::*;

  logic              all_passed;
  logic [WCLK_W-1:0] max_val;
  logic [WCLK_W-1:0] target;
  outcome_e          outcome;
  logic              stale_upd;
  logic              stale_same;
  logic              warn_next;

  assign req_ready = 1'b1;

  wcg_gate_eval #(.NUM_STREAMS(NUM_STREAMS)) u_gate (
    .active     (strm_active),
    .passed     (strm_passed),
    .all_passed (all_passed)
  );

  wcg_max_sel #(.NUM_STREAMS(NUM_STREAMS), .WCLK_W(WCLK_W)) u_max (
    .seed    (req_value),
    .active  (strm_active),
    .times   (strm_time),
    .max_out (max_val)
  );

  always_comb begin
    target = req_force ? req_value : max_val;
    if (req_force)              outcome = OUT_APPLIED;
    else if (!all_passed)       outcome = OUT_DELAYED;
    else if (max_val < wclk_value) outcome = OUT_BACKWARD;
    else                        outcome = OUT_APPLIED;
  end

  assign stale_upd  = req_valid && !req_force && (outcome == OUT_APPLIED);
  assign stale_same = (target == wclk_value);

  wcg_stale_track #(.STALE_LIMIT(STALE_LIMIT)) u_stale (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (stale_upd),
    .same      (stale_same),
    .warn_next (warn_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_value   <= '0;
      done_valid   <= 1'b0;
      done_applied <= 1'b0;
      err_backward <= 1'b0;
      stale_warn   <= 1'b0;
    end else begin
      done_valid   <= req_valid;
      done_applied <= req_valid && (outcome == OUT_APPLIED);
      err_backward <= req_valid && (outcome == OUT_BACKWARD);
      stale_warn   <= req_valid && warn_next;
      if (req_valid && (outcome == OUT_APPLIED)) wclk_value <= target;
    end
  end

  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done_valid); // R7
  AST_IDLE_HOLDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(wclk_value)); // R7
  AST_NO_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_force) |=> (wclk_value >= $past(wclk_value))); // R5
  AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_force && !all_passed) |=> ($stable(wclk_value) && !done_applied)); // R1
  AST_FORCE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_force) |=> (wclk_value == $past(req_value))); // R4
  AST_ERR_NOT_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    err_backward |-> (done_valid && !done_applied)); // R5
  AST_WARN_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    stale_warn |-> (done_valid && done_applied)); // R6
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready); // R9
endmodule

// File: tb/tb_wallclock_gate.sv
`timescale 1ns/1ps
module tb_wallclock_gate;
  localparam int N = 3;
  localparam int W = 64;
  localparam int LIM = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_force = 1'b0;
  logic [W-1:0]   req_value = '0;
  logic [N-1:0]   strm_active = '0;
  logic [N-1:0]   strm_passed = '0;
  logic [N*W-1:0] strm_time = '0;
  logic [W-1:0]   wclk_value;
  logic           done_valid, done_applied, err_backward, stale_warn;

  int total = 0;
  int bad = 0;
  logic [W-1:0] m_wclk = '0;
  int           m_cnt = 0;

  always #2 clk = ~clk;

  wallclock_gate #(.NUM_STREAMS(N), .WCLK_W(W), .STALE_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_force(req_force), .req_value(req_value), .strm_active(strm_active),
    .strm_passed(strm_passed), .strm_time(strm_time), .wclk_value(wclk_value),
    .done_valid(done_valid), .done_applied(done_applied),
    .err_backward(err_backward), .stale_warn(stale_warn)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic f_gate(logic [N-1:0] a, logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (a[i] && !p[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [W-1:0] f_max(logic [W-1:0] v, logic [N-1:0] a, logic [N*W-1:0] t);
    logic [W-1:0] m = v;
    for (int i = 0; i < N; i++) if (a[i] && t[i*W +: W] > m) m = t[i*W +: W];
    return m;
  endfunction

  task automatic do_req(string tag, logic f, logic [W-1:0] v, logic [N-1:0] a,
                        logic [N-1:0] p, logic [N*W-1:0] t);
    logic [W-1:0] tgt;
    logic e_app, e_err, e_stale;
    e_app = 1'b0; e_err = 1'b0; e_stale = 1'b0;
    if (f) begin
      tgt = v; e_app = 1'b1;
    end else begin
      tgt = f_max(v, a, t);
      if (f_gate(a, p)) begin
        if (tgt < m_wclk) e_err = 1'b1;
        else begin
          e_app = 1'b1;
          if (tgt == m_wclk) begin
            if (m_cnt <= LIM) m_cnt++;
            e_stale = (m_cnt > LIM);
          end else m_cnt = 0;
        end
      end
    end
    if (e_app) m_wclk = tgt;
    @(negedge clk);
    req_valid = 1'b1; req_force = f; req_value = v;
    strm_active = a; strm_passed = p; strm_time = t;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R7 done_valid"}, W'(done_valid), W'(1'b1));
    check({tag, " wclk"}, wclk_value, m_wclk);
    check({tag, " R7 applied"}, W'(done_applied), W'(e_app));
    check({tag, " R5 err"}, W'(err_backward), W'(e_err));
    check({tag, " R6 stale"}, W'(stale_warn), W'(e_stale));
  endtask

  function automatic logic [N*W-1:0] pack3(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return {c, b, a};
  endfunction

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 wclk reset", wclk_value, '0);
    check("R8 done reset", W'(done_valid), '0);
    check("R8 flags reset", W'({done_applied, err_backward, stale_warn}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready", W'(req_ready), W'(1'b1));

    do_req("R4 force up", 1'b1, 64'd100, 3'b000, 3'b000, '0);
    do_req("R1 blocked", 1'b0, 64'd120, 3'b111, 3'b101, pack3(130, 140, 150));
    do_req("R3 max", 1'b0, 64'd120, 3'b111, 3'b111, pack3(130, 140, 125));
    do_req("R2 inactive big", 1'b0, 64'd145, 3'b011, 3'b011, pack3(141, 142, 64'hFFFF));
    do_req("R2 inactive notpassed", 1'b0, 64'd150, 3'b001, 3'b001, pack3(149, 0, 0));
    do_req("R5 backward", 1'b0, 64'd90, 3'b001, 3'b001, pack3(95, 0, 0));
    do_req("R4 force down", 1'b1, 64'd80, 3'b111, 3'b000, '0);
    // R6: run of unchanged writes, interrupted by forced and delayed ones
    do_req("R6 s1", 1'b0, 64'd80, 3'b000, 3'b000, '0);
    do_req("R6 s2", 1'b0, 64'd80, 3'b001, 3'b001, pack3(70, 0, 0));
    do_req("R6 force same", 1'b1, 64'd80, 3'b000, 3'b000, '0);
    do_req("R6 delayed", 1'b0, 64'd99, 3'b001, 3'b000, '0);
    do_req("R6 s3", 1'b0, 64'd80, 3'b000, 3'b000, '0);
    do_req("R6 s4", 1'b0, 64'd80, 3'b000, 3'b000, '0);
    do_req("R6 s5", 1'b0, 64'd80, 3'b000, 3'b000, '0);
    do_req("R6 change", 1'b0, 64'd81, 3'b000, 3'b000, '0);
    do_req("R6 after clear", 1'b0, 64'd81, 3'b000, 3'b000, '0);

    for (int k = 0; k < 400; k++) begin
      logic [N*W-1:0] t;
      logic [W-1:0] v;
      logic f;
      for (int i = 0; i < N; i++) t[i*W +: W] = m_wclk + W'($urandom % 6) - 64'd2;
      v = m_wclk + W'($urandom % 5) - 64'd2;
      f = (($urandom % 8) == 0);
      do_req("R1 R3 rand", f, v, N'($urandom), N'($urandom | $urandom), t);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule